// File: doc/BRIEF.md
# Carry-Select Registered Adder-Subtractor

This block adds or subtracts two operands of a parameterised width (a multiple of five bits). The width is split into five-bit groups. Inside each group, every bit cell works out its sum and carry for two cases at once: an incoming carry of 0 and an incoming carry of 1. These two carry rails run side by side through the group. The real carry only comes into play at the group boundary, where it picks one of the two precomputed results. The critical path therefore runs through one multiplexer per group, not through every bit.

Subtraction inverts operand B and forces the carry into the first cell to 1. The full-width result is available as a combinational output and through an output register. The register has a clock enable, a synchronous clear, a synchronous load of a separate data word, an asynchronous load of that same word, and an active-low asynchronous clear.

Top module: `csa_addsub`

## Requirements
- R1: With sub_i=0, sum_o equals (a_i + b_i + cin_i) modulo 2^WIDTH, combinationally.
- R2: With sub_i=1, sum_o equals (a_i - b_i) modulo 2^WIDTH, and cin_i has no effect.
- R3: cout_o is bit WIDTH of the full-width sum a_i + b_i + cin_i when adding, and of a_i + ~b_i + 1 when subtracting, so 1 means no borrow.
- R4: A carry generated in bit 0 resolves correctly through every group boundary (for example, all-ones plus one gives zero with cout_o=1), and in every group a carry on the 0-rail implies a carry on the 1-rail.
- R5: On a rising clock edge with en_i=1 and sclr_i=1, q_o becomes 0, whatever the value of sload_i.
- R6: On a rising clock edge with en_i=1, sclr_i=0 and sload_i=1, q_o becomes ld_data_i.
- R7: On a rising clock edge with en_i=1, sclr_i=0 and sload_i=0, q_o becomes the value sum_o had before the edge.
- R8: On a rising clock edge with en_i=0, q_o keeps its value, even when sclr_i or sload_i is 1.
- R9: A rising aload_i loads ld_data_i into q_o at once, with no clock edge. While aload_i stays high, the register ignores its synchronous controls.
- R10: rst_ni=0 clears q_o to 0 at once and overrides aload_i and every synchronous control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous clear, active low |
| aload_i | input | 1 | Asynchronous load of ld_data_i |
| en_i | input | 1 | Clock enable for the synchronous controls |
| sclr_i | input | 1 | Synchronous clear |
| sload_i | input | 1 | Synchronous load of ld_data_i |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| cin_i | input | 1 | Carry in (used when adding) |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| ld_data_i | input | WIDTH | Load data for the synchronous and asynchronous loads |
| sum_o | output | WIDTH | Combinational result |
| cout_o | output | 1 | Carry out of the full width |
| q_o | output | WIDTH | Registered result |

## Verification
Suppose a rail mix-up or a wrong select inside a group. That corrupts sum_o right away, and only for operands whose carry reaches that group's boundary. This is why operands are chosen to ripple across each five-bit boundary and across the whole width. A fault in the register's priority or enable logic shows on q_o one clock edge after the conflicting controls are applied. A fault in the asynchronous paths shows on q_o within the same cycle, before any edge.

// File: rtl/csa_pkg.sv
package csa_pkg;
  localparam int unsigned GRP_W = 5;  // cells per carry-select group

  typedef struct packed {
    logic c0;  // carry out assuming group carry-in 0
    logic c1;  // carry out assuming group carry-in 1
  } rail_t;
endpackage

// File: rtl/csa_cell.sv
module csa_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c0_i,
  input  logic c1_i,
  output logic s0_o,
  output logic s1_o,
  output logic c0_o,
  output logic c1_o
);
  logic p, g;
  assign p    = a_i ^ b_i;
  assign g    = a_i & b_i;
  assign s0_o = p ^ c0_i;
  assign s1_o = p ^ c1_i;
  assign c0_o = g | (p & c0_i);
  assign c1_o = g | (p & c1_i);
endmodule

// File: rtl/csa_group.sv
module csa_group
  import csa_pkg::*;
(
  input  logic [GRP_W-1:0] a_i,
  input  logic [GRP_W-1:0] b_i,
  output logic [GRP_W-1:0] s0_o,
  output logic [GRP_W-1:0] s1_o,
  output rail_t            co_o
);
  logic [GRP_W:0] r0, r1;
  assign r0[0] = 1'b0;
  assign r1[0] = 1'b1;

  for (genvar i = 0; i < GRP_W; i++) begin : g_cell
    csa_cell u_cell (
      .a_i (a_i[i]),
      .b_i (b_i[i]),
      .c0_i(r0[i]),
      .c1_i(r1[i]),
      .s0_o(s0_o[i]),
      .s1_o(s1_o[i]),
      .c0_o(r0[i+1]),
      .c1_o(r1[i+1])
    );
  end

  assign co_o.c0 = r0[GRP_W];
  assign co_o.c1 = r1[GRP_W];
endmodule

// File: rtl/csa_oreg.sv
module csa_oreg #(
  parameter int unsigned WIDTH = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             aload_i,
  input  logic             en_i,
  input  logic             sclr_i,
  input  logic             sload_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic [WIDTH-1:0] ld_data_i,
  output logic [WIDTH-1:0] q_o
);
  // async clear > async load > (en) sclr > sload > d
  always_ff @(posedge clk_i or negedge rst_ni or posedge aload_i) begin
    if (!rst_ni)        q_o <= '0;
    else if (aload_i)   q_o <= ld_data_i;
    else if (en_i) begin
      if (sclr_i)       q_o <= '0;
      else if (sload_i) q_o <= ld_data_i;
      else              q_o <= d_i;
    end
  end

  a_r5_sclr_wins: assert property (@(posedge clk_i) disable iff (!rst_ni || aload_i)
    en_i && sclr_i |=> q_o == '0);
  a_r6_sload: assert property (@(posedge clk_i) disable iff (!rst_ni || aload_i)
    en_i && !sclr_i && sload_i |=> q_o == $past(ld_data_i));
  a_r7_capture: assert property (@(posedge clk_i) disable iff (!rst_ni || aload_i)
    en_i && !sclr_i && !sload_i |=> q_o == $past(d_i));
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni || aload_i)
    !en_i |=> $stable(q_o));
endmodule

// File: rtl/csa_addsub.sv
module csa_addsub
  import csa_pkg::*;
#(
  parameter int unsigned WIDTH = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             aload_i,
  input  logic             en_i,
  input  logic             sclr_i,
  input  logic             sload_i,
  input  logic             sub_i,
  input  logic             cin_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] ld_data_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned NGRP = WIDTH / GRP_W;

  logic [WIDTH-1:0] b_eff;
  logic [NGRP:0]    carry;
  rail_t            grp_co [NGRP];

  assign b_eff    = b_i ^ {WIDTH{sub_i}};
  assign carry[0] = sub_i | cin_i;  // subtract forces first-cell carry to 1

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GRP_W-1:0] s0, s1;
    csa_group u_grp (
      .a_i (a_i[g*GRP_W +: GRP_W]),
      .b_i (b_eff[g*GRP_W +: GRP_W]),
      .s0_o(s0),
      .s1_o(s1),
      .co_o(grp_co[g])
    );
    assign sum_o[g*GRP_W +: GRP_W] = carry[g] ? s1 : s0;
    assign carry[g+1] = carry[g] ? grp_co[g].c1 : grp_co[g].c0;

    a_r4_rail_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grp_co[g].c0 |-> grp_co[g].c1);
  end

  assign cout_o = carry[NGRP];

  csa_oreg #(.WIDTH(WIDTH)) u_oreg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .aload_i  (aload_i),
    .en_i     (en_i),
    .sclr_i   (sclr_i),
    .sload_i  (sload_i),
    .d_i      (sum_o),
    .ld_data_i(ld_data_i),
    .q_o      (q_o)
  );

  a_r1_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sub_i |-> {cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + (WIDTH+1)'(cin_i)));
  a_r2_sub: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_i |-> {cout_o, sum_o} == ({1'b0, a_i} + {1'b0, ~b_i} + (WIDTH+1)'(1)));
endmodule

// File: tb/sim_csa_addsub.sv
`timescale 1ns/1ps
module sim_csa_addsub;
  localparam int unsigned W = 20;
  localparam logic [W-1:0] MASK = {W{1'b1}};

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         sub;
    logic         cin;
    logic [W-1:0] s;
    logic         co;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{20'h00001, 20'h00002, 1'b0, 1'b0, 20'h00003, 1'b0},
    '{20'hFFFFF, 20'h00001, 1'b0, 1'b0, 20'h00000, 1'b1},
    '{20'hFFFFF, 20'hFFFFF, 1'b0, 1'b1, 20'hFFFFF, 1'b1},
    '{20'h00000, 20'h00000, 1'b0, 1'b1, 20'h00001, 1'b0},
    '{20'h00005, 20'h00003, 1'b1, 1'b0, 20'h00002, 1'b1},
    '{20'h00003, 20'h00005, 1'b1, 1'b0, 20'hFFFFE, 1'b0},
    '{20'h00000, 20'h00000, 1'b1, 1'b0, 20'h00000, 1'b1},
    '{20'h0001F, 20'h00001, 1'b0, 1'b0, 20'h00020, 1'b0},
    '{20'h003FF, 20'h00001, 1'b0, 1'b0, 20'h00400, 1'b0},
    '{20'h12345, 20'h0ABCD, 1'b0, 1'b0, 20'h1CF12, 1'b0},
    '{20'h00010, 20'h00001, 1'b1, 1'b1, 20'h0000F, 1'b1},
    '{20'h80000, 20'h7FFFF, 1'b1, 1'b0, 20'h00001, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, aload = 1'b0, en = 1'b0, sclr = 1'b0, sload = 1'b0;
  logic sub = 1'b0, cin = 1'b0;
  logic [W-1:0] a = '0, b = '0, ld = '0;
  logic [W-1:0] sum, q;
  logic cout;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  csa_addsub #(.WIDTH(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .aload_i(aload), .en_i(en), .sclr_i(sclr),
    .sload_i(sload), .sub_i(sub), .cin_i(cin), .a_i(a), .b_i(b),
    .ld_data_i(ld), .sum_o(sum), .cout_o(cout), .q_o(q)
  );

  task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic apply(input logic [W-1:0] ta, tb, input logic ts, tc);
    a = ta; b = tb; sub = ts; cin = tc; #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R10 reset state", {1'b0, q}, '0);
    @(negedge clk); rst_n = 1'b1; en = 1'b1;

    // table walk: combinational result, then registered capture
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VECS[i].a, VECS[i].b, VECS[i].sub, VECS[i].cin);
      chk(VECS[i].sub ? "R2 sub table" : "R1 add table", {1'b0, sum}, {1'b0, VECS[i].s});
      chk(i == 1 ? "R4 full ripple" : "R3 cout table", {{W{1'b0}}, cout}, {{W{1'b0}}, VECS[i].co});
      step();
      chk("R7 capture", {1'b0, q}, {1'b0, VECS[i].s});
    end

    // carry across each group boundary
    for (int g = 1; g < W / 5; g++) begin
      @(negedge clk);
      apply(MASK >> (W - 5*g), 20'h00001, 1'b0, 1'b0);
      chk("R4 boundary", {cout, sum}, {1'b0, 20'h00001 << (5*g)});
    end

    // random operands against behavioural reference
    for (int i = 0; i < 200; i++) begin
      logic [W-1:0] ra, rb;
      logic rs, rc;
      logic [W:0] exp;
      ra = W'($urandom); rb = W'($urandom); rs = 1'($urandom); rc = 1'($urandom);
      @(negedge clk);
      apply(ra, rb, rs, rc);
      exp = rs ? ({1'b0, ra} + {1'b0, ~rb} + 1) : ({1'b0, ra} + {1'b0, rb} + (W+1)'(rc));
      chk(rs ? "R2 random" : "R1 random", {cout, sum}, exp);
    end

    // synchronous controls
    @(negedge clk);
    apply(20'h00100, 20'h00023, 1'b0, 1'b0);
    ld = 20'hABCDE; sload = 1'b1; step();
    chk("R6 sload", {1'b0, q}, {1'b0, 20'hABCDE});
    sclr = 1'b1; step();
    chk("R5 sclr over sload", {1'b0, q}, '0);
    sclr = 1'b0; sload = 1'b0; step();
    chk("R7 after controls", {1'b0, q}, {1'b0, 20'h00123});
    en = 1'b0; sclr = 1'b1; step();
    chk("R8 hold with sclr", {1'b0, q}, {1'b0, 20'h00123});
    sclr = 1'b0; sload = 1'b1; step();
    chk("R8 hold with sload", {1'b0, q}, {1'b0, 20'h00123});
    sload = 1'b0;

    // async load between edges
    @(negedge clk);
    ld = 20'h55AA5; aload = 1'b1; #1;
    chk("R9 aload immediate", {1'b0, q}, {1'b0, 20'h55AA5});
    en = 1'b1; sclr = 1'b1; step();
    chk("R9 aload over sclr", {1'b0, q}, {1'b0, 20'h55AA5});
    aload = 1'b0; sclr = 1'b0; #1;

    // async clear over aload
    @(negedge clk);
    aload = 1'b1; rst_n = 1'b0; #1;
    chk("R10 clear over aload", {1'b0, q}, '0);
    aload = 1'b0; #1;
    step();
    chk("R10 clear held", {1'b0, q}, '0);
    rst_n = 1'b1; step();
    chk("R7 after reset", {1'b0, q}, {1'b0, 20'h00123});

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule